// File: doc/BRIEF.md
# Pipelined Histogram Accumulator with Constant-Time Clear

This block builds a histogram in on-chip RAM. Each cycle a strobe may present one bin index. The block reads that bin, adds one, and writes the sum back to the same bin. The read, add and write are spread over three cycles. Because of that spacing, a bin can be hit again before its earlier update has reached the RAM. Two forwarding registers hold the most recent writes, and a matching in-flight value replaces the stale RAM word. Every hit therefore counts, even when the same bin is hit on every cycle.

Clearing does not rewrite the count RAM. A small run number is kept, and a second RAM stores, for each bin, the run number that was current when the bin was last written. A bin whose stored run number differs from the current one reads as zero, both in the update path and on the readout port. A clear request therefore only advances the run number, which takes one cycle. When the run number is already at its top value, the block instead enters a sweep that writes zero into every entry of the tag RAM, one per cycle. The run number then restarts at 1. Reset also starts this sweep.

The controller has two states. WIPE sweeps the tag RAM and asserts `busy`. RUN accepts hits and clears. The transitions are:
- Reset enters WIPE.
- WIPE goes to RUN after the cycle that writes the last address.
- RUN goes to WIPE on a clear request while the run number is at its top value.
- Any other clear request keeps the block in RUN and advances the run number.

Top module: `tag_cleared_histogram`

## Requirements
- R1: After reset is released, `busy` is 1 for exactly BINS cycles and then 0. While reset is held, `busy` is 1 and `rd_count` is 0.
- R2: A hit presented in cycle u (with `hit_valid` = 1 and `busy` = 0) adds one to bin `hit_bin`. A readout requested in cycle v is shown on `rd_count` in cycle v+1. It includes every hit presented up to cycle v-3.
- R3: Hits to the same bin are counted exactly for any spacing, including consecutive cycles and gaps of one or two cycles.
- R4: Counts are CW bits wide and wrap modulo 2^CW. With CW=16, 65537 hits on a bin leave the value 1.
- R5: A clear request in RUN below the top run value makes every bin read 0 for readouts requested in the clear cycle or later, until the bin is hit again. `busy` stays 0. A hit presented in the same cycle as the clear is counted.
- R6: Hits presented before the clear cycle are discarded, including those whose write-back has not yet reached the RAM.
- R7: The run number starts at 1 after each sweep. Clears advance it by one up to 2^TW-1. A clear request at 2^TW-1 raises `busy` in the next cycle for BINS cycles. A hit presented in that cycle is discarded, and afterwards every bin reads 0.
- R8: While `busy` is 1, `hit_valid` and `clear_req` have no effect, and `rd_count` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a tag sweep |
| hit_valid | input | 1 | Strobe: count one hit on `hit_bin` this cycle |
| hit_bin | input | AW | Bin index of the hit, below BINS |
| clear_req | input | 1 | Request to zero all bins |
| rd_bin | input | AW | Bin index to read out |
| rd_count | output | CW | Count of the bin requested in the previous cycle |
| busy | output | 1 | Tag sweep in progress (state WIPE) |

## Verification
The assertions assume that `hit_bin` and `rd_bin` are always below BINS. They also assume that the clock keeps running through a sweep, so the count of busy cycles is exact. Every index in the stimulus is drawn below BINS. The stimulus mixes three kinds of traffic: dense repeats on one to four bins to stress forwarding, clears that overlap in-flight hits, and a run of clears long enough to force the sweep. Hits and clears are also driven while `busy` is 1, to show that they are ignored.

// File: rtl/hist_pkg.sv
package hist_pkg;
    typedef enum logic {
        ST_WIPE = 1'b0,
        ST_RUN  = 1'b1
    } hist_state_t;
endpackage

// File: rtl/hist_dpram.sv
// One write port and two synchronous read ports.
// A read on the same edge as a write to that address returns the old word.
module hist_dpram #(
    parameter int W     = 16,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  qa,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  qb
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
        qa <= mem[ra_a];
        qb <= mem[ra_b];
    end
endmodule

// File: rtl/hist_ctrl.sv
// Run-number bookkeeping and tag-sweep controller.
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int BINS = 256,
    parameter int TW   = 4,
    parameter int AW   = $clog2(BINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_req,
    output hist_state_t   state,
    output logic [TW-1:0] run,
    output logic          flush,
    output logic          take_ok,
    output logic          wipe_we,
    output logic [AW-1:0] wipe_addr
);
    localparam logic [TW-1:0] RUN_TOP = '1;
    localparam logic [AW-1:0] LAST_A  = AW'(BINS - 1);

    hist_state_t   nxt;
    logic [AW-1:0] wp;
    logic          last;

    assign last      = (wp == LAST_A);
    assign wipe_addr = wp;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WIPE: if (last) nxt = ST_RUN;
            ST_RUN:  if (clear_req && run == RUN_TOP) nxt = ST_WIPE;
            default: nxt = state;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WIPE;
        else        state <= nxt;
    end

    // run number and sweep address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
            wp  <= '0;
        end else begin
            unique case (state)
                ST_WIPE: begin
                    wp <= wp + 1'b1;
                    if (last) run <= TW'(1);
                end
                ST_RUN: begin
                    if (clear_req) begin
                        wp <= '0;
                        if (run != RUN_TOP) run <= run + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_WIPE: begin
                wipe_we = 1'b1;
                flush   = 1'b0;
                take_ok = 1'b0;
            end
            ST_RUN: begin
                wipe_we = 1'b0;
                flush   = clear_req;
                take_ok = !(clear_req && run == RUN_TOP);
            end
            default: begin
                wipe_we = 1'b0;
                flush   = 1'b0;
                take_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tag_cleared_histogram.sv
module tag_cleared_histogram
    import hist_pkg::*;
#(
    parameter int BINS = 256,
    parameter int CW   = 16,
    parameter int TW   = 4,
    parameter int AW   = $clog2(BINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_valid,
    input  logic [AW-1:0] hit_bin,
    input  logic          clear_req,
    input  logic [AW-1:0] rd_bin,
    output logic [CW-1:0] rd_count,
    output logic          busy
);
    // Writes that may still be missing from a RAM read: one RAM latency + one stage register.
    localparam int FWD = 2;

    hist_state_t   state;
    logic [TW-1:0] run_q;
    logic          flush, take_ok, wipe_we;
    logic [AW-1:0] wipe_addr;

    hist_ctrl #(.BINS(BINS), .TW(TW), .AW(AW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .clear_req(clear_req),
        .state(state), .run(run_q), .flush(flush), .take_ok(take_ok),
        .wipe_we(wipe_we), .wipe_addr(wipe_addr)
    );

    assign busy = (state == ST_WIPE);

    // stage 1: index registered alongside the RAM read
    logic          s1_v;
    logic [AW-1:0] s1_bin;
    // stage 2: RAM data registered, add and write back
    logic          s2_v;
    logic [AW-1:0] s2_bin;
    logic [CW-1:0] s2_cnt;
    logic [TW-1:0] s2_tag;

    logic [CW-1:0] cnt_qa, cnt_qb;
    logic [TW-1:0] tag_qa, tag_qb;
    logic [CW-1:0] upd;
    logic          upd_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_bin <= '0;
            s2_v   <= 1'b0;
            s2_bin <= '0;
            s2_cnt <= '0;
            s2_tag <= '0;
        end else begin
            s1_v   <= hit_valid && take_ok;
            s1_bin <= hit_bin;
            s2_v   <= s1_v && !flush;
            s2_bin <= s1_bin;
            s2_cnt <= cnt_qa;
            s2_tag <= tag_qa;
        end
    end

    // forwarding registers, index 0 holds the newest write
    logic          fw_v   [FWD];
    logic [AW-1:0] fw_bin [FWD];
    logic [CW-1:0] fw_val [FWD];
    logic [CW-1:0] pick   [FWD+1];

    assign pick[FWD] = (s2_tag == run_q) ? s2_cnt : '0;

    generate
        for (genvar i = FWD - 1; i >= 0; i--) begin : g_fwd
            assign pick[i] = (fw_v[i] && fw_bin[i] == s2_bin) ? fw_val[i] : pick[i+1];
        end
    endgenerate

    assign upd    = pick[0] + CW'(1);
    assign upd_we = s2_v && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FWD; i++) begin
                fw_v[i]   <= 1'b0;
                fw_bin[i] <= '0;
                fw_val[i] <= '0;
            end
        end else begin
            fw_v[0]   <= upd_we;
            fw_bin[0] <= s2_bin;
            fw_val[0] <= upd;
            for (int i = 1; i < FWD; i++) begin
                fw_v[i]   <= fw_v[i-1] && !flush;
                fw_bin[i] <= fw_bin[i-1];
                fw_val[i] <= fw_val[i-1];
            end
        end
    end

    hist_dpram #(.W(CW), .DEPTH(BINS), .AW(AW)) cnt_ram_i (
        .clk(clk), .we(upd_we), .wa(s2_bin), .wd(upd),
        .ra_a(hit_bin), .qa(cnt_qa), .ra_b(rd_bin), .qb(cnt_qb)
    );

    hist_dpram #(.W(TW), .DEPTH(BINS), .AW(AW)) tag_ram_i (
        .clk(clk), .we(upd_we || wipe_we),
        .wa(wipe_we ? wipe_addr : s2_bin),
        .wd(wipe_we ? '0 : run_q),
        .ra_a(hit_bin), .qa(tag_qa), .ra_b(rd_bin), .qb(tag_qb)
    );

    // readout: qualify the word with the run number
    logic rd_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_ok <= 1'b0;
        else        rd_ok <= !busy && !clear_req;
    end

    assign rd_count = (rd_ok && tag_qb == run_q) ? cnt_qb : '0;
endmodule

// File: rtl/hist_checker.sv
module hist_checker #(
    parameter int BINS = 256,
    parameter int CW   = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          clear_req,
    input logic [CW-1:0] rd_count
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    assert_rd_zero_while_busy_R8: assert property (
        @(posedge clk) disable iff (!rst_n) busy |-> rd_count == '0);

    assert_clear_zeroes_R5: assert property (
        @(posedge clk) disable iff (!rst_n) clear_req |=> rd_count == '0);

    // covers the sweep after reset (R1) and after a run-number wrap (R7)
    assert_wipe_len_R1: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(busy) |-> busy_len == BINS);

    assert_busy_from_clear_R7: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(clear_req));
endmodule

bind tag_cleared_histogram hist_checker #(.BINS(BINS), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .clear_req(clear_req), .rd_count(rd_count)
);

// File: tb/tag_cleared_histogram_tb_top.sv
module tag_cleared_histogram_tb_top;
    localparam int BINS  = 256;
    localparam int CW    = 16;
    localparam int TW    = 4;
    localparam int AW    = $clog2(BINS);
    localparam int MASK  = (1 << CW) - 1;
    localparam int RTOP  = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_valid = 1'b0;
    logic [AW-1:0] hit_bin = '0;
    logic          clear_req = 1'b0;
    logic [AW-1:0] rd_bin = '0;
    logic [CW-1:0] rd_count;
    logic          busy;

    always #10 clk = ~clk;

    tag_cleared_histogram #(.BINS(BINS), .CW(CW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_bin(hit_bin),
        .clear_req(clear_req), .rd_bin(rd_bin), .rd_count(rd_count), .busy(busy)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int M [BINS];
    int wipe_left;
    int run_m;
    int h1v, h1b, h2v, h2b;
    int exp_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BINS; i++) M[i] = 0;
            wipe_left = BINS; run_m = 1;
            h1v = 0; h2v = 0; h1b = 0; h2b = 0; exp_rd = 0;
        end else begin
            bit was_busy, clr, take;
            was_busy = (wipe_left > 0);
            clr  = clear_req && !was_busy;
            take = hit_valid && !was_busy && !(clr && run_m == RTOP);
            exp_rd = (!was_busy && !clear_req) ? M[rd_bin] : 0;
            if (was_busy) wipe_left--;
            if (clr) begin
                for (int i = 0; i < BINS; i++) M[i] = 0;
                h2v = 0;
                if (run_m == RTOP) begin
                    wipe_left = BINS;
                    run_m = 1;
                end else run_m++;
            end else begin
                if (h2v != 0) M[h2b] = (M[h2b] + 1) & MASK;
                h2v = h1v; h2b = h1b;
            end
            h1v = take ? 1 : 0;
            h1b = int'(hit_bin);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", int'(busy), 1, "busy in reset");
            chk("R1", int'(rd_count), 0, "rd_count in reset");
        end else begin
            chk(cur_req, int'(busy), (wipe_left > 0) ? 1 : 0, "busy");
            chk(cur_req, int'(rd_count), exp_rd, "rd_count");
        end
    end

    task automatic cyc(bit v, int b, bit c);
        @(negedge clk);
        hit_valid = v;
        hit_bin   = AW'(b);
        clear_req = c;
        rd_bin    = rd_bin + 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(BINS + 4);

        cur_req = "R2";  // sparse hits, spacing of three cycles or more
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1, (i * 7) % BINS, 1'b0);
            idle(2);
        end
        idle(BINS);

        cur_req = "R3";  // consecutive and gapped repeats
        for (int i = 0; i < 12; i++) cyc(1'b1, 9, 1'b0);
        for (int i = 0; i < 12; i++) cyc(1'b1, 10 + (i % 2), 1'b0);
        for (int i = 0; i < 12; i++) cyc(1'b1, 20 + (i % 3), 1'b0);
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, 30, 1'b0);
            cyc(1'b0, 0, 1'b0);
        end
        for (int i = 0; i < 400; i++) cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3), 1'b0);
        idle(BINS);

        cur_req = "R5";  // clear with a hit in the same cycle
        cyc(1'b1, 40, 1'b0);
        cyc(1'b1, 41, 1'b1);
        cyc(1'b1, 41, 1'b0);
        idle(BINS);

        cur_req = "R6";  // hits still in flight at the clear
        cyc(1'b1, 50, 1'b0);
        cyc(1'b1, 50, 1'b0);
        cyc(1'b1, 51, 1'b0);
        cyc(1'b0, 0, 1'b1);
        idle(BINS);

        cur_req = "R4";  // wrap of a count
        cyc(1'b0, 0, 1'b1);
        for (int i = 0; i < MASK + 2; i++) cyc(1'b1, 60, 1'b0);
        idle(BINS);

        cur_req = "R7";  // clears until the run number tops out
        for (int n = 0; n < 2 * RTOP; n++) begin
            if (wipe_left > 0) break;
            cyc(1'b1, 70, 1'b0);
            cyc(1'b1, 71, 1'b0);
            cyc(1'b1, 72, 1'b1);
            idle(4);
        end

        cur_req = "R8";  // hits and clears during the sweep
        for (int i = 0; i < BINS + 8; i++) cyc(1'b1, i % 4, (i % 5) == 0);
        cur_req = "R7";
        idle(BINS + 4);

        cur_req = "R2";
        for (int i = 0; i < 20; i++) cyc(1'b1, 80 + (i % 4), 1'b0);
        idle(BINS);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule